// File: doc/BRIEF.md
# Word-Clock Synchronization Monitor

This block runs on the system clock and checks the incoming word clock and bit clock against it. It counts system clocks between rising word-clock edges and classifies the count against six accepted system-clock-to-sample-rate ratios: 128, 192, 256, 384, 512 and 768. A count within two clocks of an accepted ratio is treated as that ratio. A ratio is only taken on when two consecutive counts agree on it. A count that fits no ratio, or that jumps between ratios, raises a clock-fault flag and keeps the output path at midscale.

Once a ratio is locked, the block runs an internal frame counter of the nominal frame length. It measures how far the real word-clock edge lies from the frame boundary it expected, counting bit-clock rising edges. When that distance exceeds six bit clocks, the block emits a one-cycle resync pulse. It then realigns its frame to a real word-clock edge and holds the force-midscale signal for two full frames before normal output resumes. Downstream logic replaces samples with the zero code while force-midscale is high.

The controller has four states. ACQUIRE waits for a ratio. SETTLE holds midscale for two frames after an alignment. TRACK is normal operation with phase checking. REALIGN waits for the next word-clock edge after an early slip. The transitions are:
- LOCK: ACQUIRE to SETTLE.
- SETTLED: SETTLE to TRACK.
- SLIP_AT_EDGE: TRACK to SETTLE, when the slip is seen on a word-clock edge.
- SLIP: TRACK to REALIGN.
- REALIGNED: REALIGN to SETTLE.
- LOSS: SETTLE, TRACK or REALIGN back to ACQUIRE, on a timeout or on two off-ratio counts in a row.

Top module: `wclk_sync_mon`

## Requirements
- R1: While and after reset, before any word-clock edge, ratio_code is 7 (none), clk_fault is 0, force_mid is 1 and resync_pulse is 0.
- R2: ratio_code gives 0, 1, 2, 3, 4 or 5 for 128, 192, 256, 384, 512 or 768 system clocks per word-clock period. A ratio is accepted after two consecutive periods, measured between rising word-clock edges, that each fall within ±2 clocks of the same ratio. clk_fault is 0 once the ratio is accepted.
- R3: A period 3 or more clocks away from every accepted ratio sets clk_fault to 1, leaves ratio_code at 7 and keeps force_mid at 1. A period 2 clocks away from a ratio is still accepted.
- R4: Consecutive periods that match different ratios, such as 256 and 384 in alternation, never lock, and they set clk_fault to 1.
- R5: Once word-clock edges have been seen, 771 system clocks (more than 768 + 2) without a rising word-clock edge set clk_fault to 1, set ratio_code to 7 and set force_mid to 1.
- R6: In TRACK, the phase error is the number of bit-clock rising edges after the first of the expected frame boundary and the real word-clock edge, up to and including the second. An error above 6 produces exactly one resync_pulse of one cycle, whether the edge is late or early. An error of 6 or less produces none.
- R7: After a resync, the frame is realigned to a real word-clock edge, and force_mid stays 1 for two full frames from that edge. It then returns to 0, and a steady input gives no further pulses.
- R8: force_mid is 0 only in TRACK. After a lock, force_mid stays 1 for two frames before going to 0.
- R9: During SETTLE and TRACK, a single off-ratio period does not raise clk_fault; only two consecutive ones do. A resync that occurs in the same cycle as an off-ratio period takes precedence over it.
- R10: After a fault, a new valid lock clears clk_fault and restores ratio_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Bit clock, synchronous to clk |
| word_clk | input | 1 | Word (frame) clock, synchronous to clk |
| ratio_code | output | 3 | Locked ratio code 0..5, or 7 when none |
| clk_fault | output | 1 | Unsupported, unstable or missing word clock |
| resync_pulse | output | 1 | One-cycle pulse on a phase slip beyond the limit |
| force_mid | output | 1 | Hold outputs at the zero code |

## Verification
The bench targets the boundaries where a slightly wrong design would still look plausible.

- Tolerance: periods of 258 and 254 must lock while 259 and 253 must not; a comparison off by one in either direction shows up there.
- Slip threshold: phase slips of exactly six and seven bit clocks are applied, late and early. A counter that includes the opening edge, or that compares with `>=`, fires on six.
- Early slips: an early slip also produces one off-ratio period. A design that faults on a single bad count would raise clk_fault when it should only resync.
- Settle and stall: the two-frame midscale hold is sampled in the middle of the last held frame and just after it. A stalled word clock is checked both before and after the timeout count.

// File: rtl/wsm_pkg.sv
`timescale 1ns/1ps
package wsm_pkg;

    localparam int NUM_RATIOS = 6;

    typedef logic [2:0] ratio_code_t;
    localparam ratio_code_t CODE_NONE = 3'd7;

    typedef enum logic [1:0] {
        ST_ACQUIRE,
        ST_SETTLE,
        ST_TRACK,
        ST_REALIGN
    } mon_state_t;

    // 128, 192, 256, 384, 512, 768 for codes 0..5; 0 otherwise
    function automatic int unsigned ratio_value(input ratio_code_t code);
        int unsigned base;
        if (code > ratio_code_t'(NUM_RATIOS - 1)) return 0;
        base = code[0] ? 192 : 128;
        return base << (code >> 1);
    endfunction

    localparam int MAX_RATIO = 768;

endpackage

// File: rtl/wsm_edge_det.sv
`timescale 1ns/1ps
module wsm_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '1;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/wsm_period_meter.sv
`timescale 1ns/1ps
module wsm_period_meter #(
    parameter int LIMIT = 771,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] meas_o,
    output logic             timeout_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             have_edge_q;

    assign meas_valid_o = edge_i & have_edge_q;
    assign meas_o       = cnt_q;
    assign timeout_o    = have_edge_q & ~edge_i & (cnt_q == CNT_W'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            have_edge_q <= 1'b0;
        end else begin
            if (edge_i)
                cnt_q <= CNT_W'(1);
            else if (cnt_q != CNT_W'(LIMIT))
                cnt_q <= cnt_q + 1'b1;

            if (edge_i)
                have_edge_q <= 1'b1;
            else if (timeout_o)
                have_edge_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wsm_ratio_match.sv
`timescale 1ns/1ps
module wsm_ratio_match
    import wsm_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int TOL   = 2
) (
    input  logic [CNT_W-1:0] count_i,
    output logic             hit_o,
    output ratio_code_t      code_o
);
    logic [NUM_RATIOS-1:0] hit_vec;

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
        localparam int REF = int'(ratio_value(ratio_code_t'(i)));
        assign hit_vec[i] = (int'(count_i) >= REF - TOL) &&
                            (int'(count_i) <= REF + TOL);
    end

    always_comb begin
        hit_o  = |hit_vec;
        code_o = CODE_NONE;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit_vec[i]) code_o = ratio_code_t'(i);
        end
    end
endmodule

// File: rtl/wsm_phase_track.sv
`timescale 1ns/1ps
module wsm_phase_track #(
    parameter int LIMIT = 6,
    localparam int ERR_W = $clog2(LIMIT + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic exp_i,
    input  logic act_i,
    input  logic tick_i,
    output logic slip_o
);
    logic             pend_exp_q;
    logic             pend_act_q;
    logic [ERR_W-1:0] err_q;
    logic             open_w;
    logic             close_w;
    logic             step_w;

    always_comb begin
        open_w  = pend_exp_q | pend_act_q;
        close_w = (pend_exp_q & act_i) | (pend_act_q & exp_i);
        step_w  = open_w & tick_i;
        slip_o  = enable_i & step_w & (err_q == ERR_W'(LIMIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_exp_q <= 1'b0;
            pend_act_q <= 1'b0;
            err_q      <= '0;
        end else if (!enable_i || slip_o || close_w) begin
            pend_exp_q <= 1'b0;
            pend_act_q <= 1'b0;
            err_q      <= '0;
        end else if (!open_w) begin
            pend_exp_q <= exp_i & ~act_i;
            pend_act_q <= act_i & ~exp_i;
            err_q      <= '0;
        end else if (step_w) begin
            err_q <= err_q + 1'b1;
        end
    end
endmodule

// File: rtl/wclk_sync_mon.sv
`timescale 1ns/1ps
module wclk_sync_mon
    import wsm_pkg::*;
#(
    parameter int TOL           = 2,
    parameter int PHASE_LIMIT   = 6,
    parameter int SETTLE_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_clk,
    input  logic       word_clk,
    output logic [2:0] ratio_code,
    output logic       clk_fault,
    output logic       resync_pulse,
    output logic       force_mid
);
    localparam int TIMEOUT  = MAX_RATIO + TOL + 1;
    localparam int CNT_W    = $clog2(TIMEOUT + 1);
    localparam int SETTLE_W = $clog2(SETTLE_FRAMES + 1);

    mon_state_t       state_q, state_n;
    ratio_code_t      ratio_q, cand_q, hit_code;
    logic             cand_ok_q, fault_q, miss_q, resync_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [CNT_W-1:0] fcnt_q, frame_len, meas;
    logic [1:0]       rise;
    logic             wck_rise, bck_rise;
    logic             meas_valid, timeout, hit, slip;
    logic             exp_evt, good_meas, bad_meas, second_bad;
    logic             lock_evt, settle_done, align_evt, to_acq;

    wsm_edge_det #(.N(2)) u_edges (
        .clk(clk), .rst_n(rst_n),
        .sig_i({bit_clk, word_clk}), .rise_o(rise)
    );
    assign wck_rise = rise[0];
    assign bck_rise = rise[1];

    wsm_period_meter #(.LIMIT(TIMEOUT)) u_meter (
        .clk(clk), .rst_n(rst_n), .edge_i(wck_rise),
        .meas_valid_o(meas_valid), .meas_o(meas), .timeout_o(timeout)
    );

    wsm_ratio_match #(.CNT_W(CNT_W), .TOL(TOL)) u_match (
        .count_i(meas), .hit_o(hit), .code_o(hit_code)
    );

    wsm_phase_track #(.LIMIT(PHASE_LIMIT)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .enable_i(state_q == ST_TRACK),
        .exp_i(exp_evt), .act_i(wck_rise), .tick_i(bck_rise),
        .slip_o(slip)
    );

    always_comb begin
        frame_len   = CNT_W'(ratio_value(ratio_q));
        exp_evt     = (fcnt_q == '0);
        good_meas   = meas_valid & hit & (hit_code == ratio_q);
        bad_meas    = meas_valid & ~good_meas;
        second_bad  = bad_meas & miss_q;
        lock_evt    = meas_valid & hit & cand_ok_q & (hit_code == cand_q);
        settle_done = exp_evt & (settle_q == SETTLE_W'(SETTLE_FRAMES - 1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACQUIRE;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_ACQUIRE: begin
                if (lock_evt) state_n = ST_SETTLE;               // LOCK
            end
            ST_SETTLE: begin
                if (timeout || second_bad) state_n = ST_ACQUIRE;  // LOSS
                else if (settle_done)      state_n = ST_TRACK;    // SETTLED
            end
            ST_TRACK: begin
                if (timeout)         state_n = ST_ACQUIRE;        // LOSS
                else if (slip)       state_n = wck_rise ? ST_SETTLE   // SLIP_AT_EDGE
                                                        : ST_REALIGN; // SLIP
                else if (second_bad) state_n = ST_ACQUIRE;        // LOSS
            end
            ST_REALIGN: begin
                if (timeout)       state_n = ST_ACQUIRE;          // LOSS
                else if (wck_rise) state_n = ST_SETTLE;           // REALIGNED
            end
        endcase
    end

    assign align_evt = (state_n == ST_SETTLE)  && (state_q != ST_SETTLE);
    assign to_acq    = (state_n == ST_ACQUIRE) && (state_q != ST_ACQUIRE);

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt_q    <= '0;
            settle_q  <= '0;
            ratio_q   <= CODE_NONE;
            cand_q    <= CODE_NONE;
            cand_ok_q <= 1'b0;
            fault_q   <= 1'b0;
            miss_q    <= 1'b0;
            resync_q  <= 1'b0;
        end else begin
            resync_q <= (state_q == ST_TRACK) & slip & ~timeout;

            if (align_evt)                    fcnt_q <= CNT_W'(1);
            else if (fcnt_q == frame_len - 1'b1) fcnt_q <= '0;
            else                              fcnt_q <= fcnt_q + 1'b1;

            if (align_evt)
                settle_q <= '0;
            else if (state_q == ST_SETTLE && exp_evt)
                settle_q <= settle_q + 1'b1;

            if (align_evt || to_acq)
                miss_q <= 1'b0;
            else if ((state_q == ST_SETTLE || state_q == ST_TRACK) && meas_valid)
                miss_q <= bad_meas;

            if (to_acq) begin
                ratio_q   <= CODE_NONE;
                cand_ok_q <= 1'b0;
                fault_q   <= 1'b1;
            end else if (state_q == ST_ACQUIRE) begin
                if (timeout) begin
                    cand_ok_q <= 1'b0;
                    fault_q   <= 1'b1;
                end else if (meas_valid) begin
                    cand_q    <= hit_code;
                    cand_ok_q <= hit;
                    if (lock_evt) begin
                        ratio_q <= hit_code;
                        fault_q <= 1'b0;
                    end else if (!hit || (cand_ok_q && hit_code != cand_q)) begin
                        fault_q <= 1'b1;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        ratio_code   = ratio_q;
        clk_fault    = fault_q;
        resync_pulse = resync_q;
        force_mid    = (state_q != ST_TRACK);
    end
endmodule

// File: rtl/wclk_sync_mon_chk.sv
`timescale 1ns/1ps
module wclk_sync_mon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ratio_code,
    input logic       clk_fault,
    input logic       resync_pulse,
    input logic       force_mid
);
    p_fault_forces_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fault |-> force_mid);

    p_fault_no_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fault |-> (ratio_code == 3'd7));

    p_track_has_ratio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !force_mid |-> (ratio_code <= 3'd5) && !clk_fault);

    p_resync_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |=> !resync_pulse);

    p_resync_holds_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |-> force_mid);
endmodule

bind wclk_sync_mon wclk_sync_mon_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code),
    .clk_fault(clk_fault), .resync_pulse(resync_pulse), .force_mid(force_mid)
);

// File: tb/wclk_sync_mon_tb_top.sv
`timescale 1ns/1ps
module wclk_sync_mon_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_clk = 1'b0;
    logic word_clk = 1'b0;
    logic [2:0] ratio_code;
    logic clk_fault, resync_pulse, force_mid;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int bph = 0;

    always #4 clk = ~clk;

    wclk_sync_mon dut_i (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .word_clk(word_clk),
        .ratio_code(ratio_code), .clk_fault(clk_fault),
        .resync_pulse(resync_pulse), .force_mid(force_mid)
    );

    always @(negedge clk) if (rst_n && resync_pulse) pulses++;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    task automatic tick(input logic w, input int d);
        @(posedge clk);
        #1;
        word_clk = w;
        bit_clk  = (bph % d) < ((d / 2 > 0) ? d / 2 : 1);
        bph++;
    endtask

    task automatic run_part(input int len, input int hi, input int d, input int from, input int to);
        for (int n = from; n < to; n++) tick(n < hi, d);
    endtask

    task automatic run_frames(input int cnt, input int len, input int d);
        for (int f = 0; f < cnt; f++) run_part(len, len / 2, d, 0, len);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0; word_clk = 1'b0; bit_clk = 1'b0; bph = 0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        pulses = 0;
    endtask

    task automatic t_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        sample();
        check("R1", "code in reset", ratio_code, 7);
        check("R1", "force_mid in reset", force_mid, 1);
        do_reset();
        run_part(256, 0, 4, 0, 20);
        sample();
        check("R1", "code idle", ratio_code, 7);
        check("R1", "fault idle", clk_fault, 0);
        check("R1", "force_mid idle", force_mid, 1);
        check("R1", "resync idle", resync_pulse, 0);
    endtask

    task automatic t_lock(input int len, input int d, input int code);
        do_reset();
        run_frames(3, len, d);
        run_part(len, len / 2, d, 0, len / 2);
        sample();
        check("R2", $sformatf("code for %0d", len), ratio_code, code);
        check("R2", $sformatf("fault for %0d", len), clk_fault, 0);
        check("R8", $sformatf("settling mid for %0d", len), force_mid, 1);
        run_part(len, len / 2, d, len / 2, len);
        run_part(len, len / 2, d, 0, len / 2);
        sample();
        check("R8", $sformatf("released for %0d", len), force_mid, 0);
        run_part(len, len / 2, d, len / 2, len);
        run_frames(4, len, d);
        sample();
        check("R6", $sformatf("no slip steady %0d", len), pulses, 0);
    endtask

    task automatic t_tolerance(input int len, input logic ok);
        do_reset();
        run_frames(3, len, 2);
        run_part(len, len / 2, 2, 0, len / 2);
        sample();
        check("R3", $sformatf("code at %0d", len), ratio_code, ok ? 2 : 7);
        check("R3", $sformatf("fault at %0d", len), clk_fault, ok ? 0 : 1);
        if (!ok) check("R3", $sformatf("mid at %0d", len), force_mid, 1);
    endtask

    task automatic t_unstable();
        do_reset();
        for (int i = 0; i < 3; i++) begin
            run_frames(1, 256, 4);
            run_frames(1, 384, 4);
        end
        sample();
        check("R4", "unstable fault", clk_fault, 1);
        check("R4", "unstable code", ratio_code, 7);
        check("R4", "unstable mid", force_mid, 1);
    endtask

    task automatic t_slip(input int k, input logic late);
        int fire;
        fire = (k > 6) ? 1 : 0;
        do_reset();
        run_frames(6, 256, 4);
        pulses = 0;
        if (late) run_part(256 + 4 * k, 128, 4, 0, 256 + 4 * k);
        else      run_part(256 - 4 * k, 128, 4, 0, 256 - 4 * k);
        run_frames(1, 256, 4);
        run_part(256, 128, 4, 0, 128);
        sample();
        check("R6", $sformatf("pulses k=%0d late=%0d", k, late), pulses, fire);
        check("R7", $sformatf("mid during settle k=%0d late=%0d", k, late), force_mid, fire);
        check("R9", $sformatf("no fault k=%0d late=%0d", k, late), clk_fault, 0);
        run_part(256, 128, 4, 128, 256);
        run_frames(2, 256, 4);
        run_part(256, 128, 4, 0, 128);
        sample();
        check("R7", $sformatf("released k=%0d late=%0d", k, late), force_mid, 0);
        run_part(256, 128, 4, 128, 256);
        run_frames(3, 256, 4);
        sample();
        check("R7", $sformatf("no repeat k=%0d late=%0d", k, late), pulses, fire);
        check("R2", $sformatf("code kept k=%0d late=%0d", k, late), ratio_code, 2);
    endtask

    task automatic t_timeout();
        do_reset();
        run_frames(6, 256, 4);
        run_part(256, 0, 4, 0, 500);
        sample();
        check("R5", "no fault before limit", clk_fault, 0);
        run_part(256, 0, 4, 0, 100);
        sample();
        check("R5", "fault after stall", clk_fault, 1);
        check("R5", "code after stall", ratio_code, 7);
        check("R5", "mid after stall", force_mid, 1);
        run_frames(6, 256, 4);
        sample();
        check("R10", "fault cleared", clk_fault, 0);
        check("R10", "code restored", ratio_code, 2);
        check("R10", "running again", force_mid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_lock(128, 2, 0);
        t_lock(192, 3, 1);
        t_lock(256, 4, 2);
        t_lock(384, 6, 3);
        t_lock(512, 8, 4);
        t_lock(768, 12, 5);
        t_tolerance(258, 1'b1);
        t_tolerance(254, 1'b1);
        t_tolerance(259, 1'b0);
        t_tolerance(253, 1'b0);
        t_unstable();
        t_slip(6, 1'b1);
        t_slip(7, 1'b1);
        t_slip(6, 1'b0);
        t_slip(7, 1'b0);
        t_timeout();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule